// File: doc/BRIEF.md
# Pipelined Single-Precision Float Comparator

This block compares two IEEE-754 single-precision operands, A and B, each on its own 32-bit bus. It returns four registered flags: A equal to B, A greater than B, A less than B, and an unordered flag for comparisons that involve a NaN. Zeros, denormals, normals, infinities, quiet NaNs and signalling NaNs are all handled.

The design has two stages. A classifier for each operand splits the operand into sign, exponent and mantissa and gives it a class. The compare logic combines the two classes with a sign-magnitude ordering, and one register stage holds the flags. The block has no handshake and applies no back-pressure. A new pair may arrive on every cycle, and each result appears one clock edge after its pair was sampled. The logic is fully synchronous, uses only the rising clock edge and has no tri-state drivers.

Top module: `fcmp_pipe`

## Requirements
- R1: The flags for the pair sampled at one rising edge are visible after that same edge and stay until the next edge. A different pair can be applied on every cycle, and each pair gets its own result.
- R2: While the synchronous active-high reset `rst` is high at a rising edge, all four flags are cleared, whatever the operand values.
- R3: If either operand is a NaN (exponent field all ones, mantissa nonzero), `flag_inv` is 1 and `flag_eq`, `flag_gt` and `flag_lt` are all 0.
- R4: Quiet NaNs (mantissa bit 22 set) and signalling NaNs (mantissa bit 22 clear, mantissa nonzero) are both unordered, with either sign.
- R5: +0 and -0 compare as equal in every sign combination.
- R6: When neither operand is a NaN, exactly one of `flag_eq`, `flag_gt` and `flag_lt` is 1 and `flag_inv` is 0.
- R7: When the signs differ (bit 31) and the operands are not both zero, the operand with sign 0 is the greater one.
- R8: When both operands are positive, the operand with the larger bits 30..0 is the greater one. Identical bit patterns are equal.
- R9: When both operands are negative, the operand with the larger bits 30..0 is the lesser one.
- R10: +infinity (0x7F800000) is greater than every finite value and -infinity (0xFF800000) is less than every finite value. Two infinities of the same sign are equal.
- R11: Denormals (exponent 0, mantissa nonzero) are ordered by value, both against each other and against the smallest normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| flag_eq | output | 1 | A equals B (registered) |
| flag_gt | output | 1 | A greater than B (registered) |
| flag_lt | output | 1 | A less than B (registered) |
| flag_inv | output | 1 | Unordered: at least one operand is a NaN (registered) |

## Verification
The bench builds the block with the default 8-bit exponent and 23-bit mantissa, which is the single-precision format. This puts the exact boundary encodings within reach: the all-ones exponent with the quiet bit at position 22, the smallest denormal 0x00000001, the largest denormal 0x007FFFFF and the largest finite value 0x7F7FFFFF. Directed pairs with hand-written expected flags come first. They are followed by a back-to-back stream of pairs built from fields, checked against an ordering model written from the requirements.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;

  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
    logic inv;
  } cmp_flags_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W,
  localparam int MAG_W  = EXP_W + MAN_W
) (
  input  logic [WORD_W-1:0] word,
  output fp_class_e         cls,
  output logic              sign,
  output logic [MAG_W-1:0]  mag
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] mant;
  logic             exp_ones;
  logic             exp_zero;
  logic             man_zero;

  assign sign     = word[WORD_W-1];
  assign mag      = word[MAG_W-1:0];
  assign expo     = word[MAG_W-1:MAN_W];
  assign mant     = word[MAN_W-1:0];
  assign exp_ones = &expo;
  assign exp_zero = ~|expo;
  assign man_zero = ~|mant;

  always_comb begin
    if (exp_ones) begin
      if (man_zero)            cls = CLS_INF;
      else if (mant[MAN_W-1])  cls = CLS_QNAN;
      else                     cls = CLS_SNAN;
    end else if (exp_zero) begin
      cls = man_zero ? CLS_ZERO : CLS_SUB;
    end else begin
      cls = CLS_NORM;
    end
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  fp_class_e        cls_a,
  input  logic             sign_a,
  input  logic [MAG_W-1:0] mag_a,
  input  fp_class_e        cls_b,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_b,
  output cmp_flags_t       res
);
  logic nan_any;
  logic both_zero;
  logic mag_gt;
  logic mag_lt;

  assign nan_any   = (cls_a == CLS_QNAN) || (cls_a == CLS_SNAN) ||
                     (cls_b == CLS_QNAN) || (cls_b == CLS_SNAN);
  assign both_zero = (cls_a == CLS_ZERO) && (cls_b == CLS_ZERO);
  assign mag_gt    = mag_a > mag_b;
  assign mag_lt    = mag_a < mag_b;

  always_comb begin
    res = '0;
    if (nan_any) begin
      res.inv = 1'b1;
    end else if (both_zero) begin
      res.eq = 1'b1;
    end else if (sign_a != sign_b) begin
      res.gt = sign_b;
      res.lt = sign_a;
    end else if (!mag_gt && !mag_lt) begin
      res.eq = 1'b1;
    end else begin
      res.gt = sign_a ? mag_lt : mag_gt;
      res.lt = sign_a ? mag_gt : mag_lt;
    end
  end
endmodule

// File: rtl/fcmp_pipe.sv
module fcmp_pipe
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W,
  localparam int MAG_W  = EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              flag_eq,
  output logic              flag_gt,
  output logic              flag_lt,
  output logic              flag_inv
);
  logic [WORD_W-1:0] ops  [2];
  fp_class_e         cls  [2];
  logic              sgn  [2];
  logic [MAG_W-1:0]  mag  [2];
  cmp_flags_t        next_flags;
  cmp_flags_t        flags_q;
  logic              live_q;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .word (ops[gi]),
      .cls  (cls[gi]),
      .sign (sgn[gi]),
      .mag  (mag[gi])
    );
  end

  fcmp_order #(.MAG_W(MAG_W)) u_order (
    .cls_a  (cls[0]),
    .sign_a (sgn[0]),
    .mag_a  (mag[0]),
    .cls_b  (cls[1]),
    .sign_b (sgn[1]),
    .mag_b  (mag[1]),
    .res    (next_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      live_q  <= 1'b0;
    end else begin
      flags_q <= next_flags;
      live_q  <= 1'b1;
    end
  end

  assign flag_eq  = flags_q.eq;
  assign flag_gt  = flags_q.gt;
  assign flag_lt  = flags_q.lt;
  assign flag_inv = flags_q.inv;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !(flag_eq || flag_gt || flag_lt || flag_inv)); // R2
  AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (rst)
    live_q && $past(cls[0] == CLS_QNAN || cls[0] == CLS_SNAN ||
                    cls[1] == CLS_QNAN || cls[1] == CLS_SNAN)
    |-> flag_inv && !flag_eq && !flag_gt && !flag_lt); // R3
  AST_ONE_RELATION: assert property (@(posedge clk) disable iff (rst)
    live_q && !flag_inv |-> $countones({flag_eq, flag_gt, flag_lt}) == 1); // R6
  AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (rst)
    live_q && $past(cls[0] == CLS_ZERO && cls[1] == CLS_ZERO) |-> flag_eq); // R5
  AST_SIGN_ORDER: assert property (@(posedge clk) disable iff (rst)
    live_q && $past(!op_a[WORD_W-1] && op_b[WORD_W-1] && cls[0] != CLS_QNAN &&
                    cls[0] != CLS_SNAN && cls[1] != CLS_QNAN && cls[1] != CLS_SNAN &&
                    !(cls[0] == CLS_ZERO && cls[1] == CLS_ZERO))
    |-> flag_gt); // R7
endmodule

// File: tb/fcmp_pipe_bench.sv
module fcmp_pipe_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        flag_eq, flag_gt, flag_lt, flag_inv;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  fcmp_pipe u_fcmp_pipe (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .flag_eq(flag_eq), .flag_gt(flag_gt), .flag_lt(flag_lt), .flag_inv(flag_inv)
  );

  localparam logic [3:0] EQ = 4'b1000, GT = 4'b0100, LT = 4'b0010, UN = 4'b0001;

  function automatic logic [3:0] model(input logic [31:0] a, input logic [31:0] b);
    logic na, nb;
    na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    if (na || nb) return UN;
    if (a[30:0] == 0 && b[30:0] == 0) return EQ;
    if (a[31] != b[31]) return a[31] ? LT : GT;
    if (a[30:0] == b[30:0]) return EQ;
    if (a[31]) return (a[30:0] > b[30:0]) ? LT : GT;
    return (a[30:0] > b[30:0]) ? GT : LT;
  endfunction

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: flags eq,gt,lt,inv = %b expected %b", tag, got, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    op_a = a;
    op_b = b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({flag_eq, flag_gt, flag_lt, flag_inv}, e, t);
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 check({flag_eq, flag_gt, flag_lt, flag_inv}, 4'b0000, "R2 reset state");
        @(negedge clk);
        rst = 1'b0;
        send(32'h3F800000, 32'h3F800000, EQ, "R8 equal patterns");
        send(32'h40000000, 32'h3F800000, GT, "R8 2>1");
        send(32'h3F800000, 32'h40000000, LT, "R8 1<2");
        send(32'hC0000000, 32'hBF800000, LT, "R9 -2<-1");
        send(32'hBF800000, 32'hC0000000, GT, "R9 -1>-2");
        send(32'hBF800000, 32'h3F800000, LT, "R7 -1<1");
        send(32'h00000001, 32'h80000001, GT, "R7 +den>-den");
        send(32'h00000000, 32'h80000000, EQ, "R5 +0=-0");
        send(32'h80000000, 32'h00000000, EQ, "R5 -0=+0");
        send(32'h80000000, 32'h80000000, EQ, "R5 -0=-0");
        send(32'h7FC00000, 32'h3F800000, UN, "R3 qnan a");
        send(32'h3F800000, 32'h7F800001, UN, "R4 snan b");
        send(32'hFF800001, 32'hFF800001, UN, "R4 neg snan both");
        send(32'hFFC00000, 32'h00000000, UN, "R4 neg qnan");
        send(32'h7F800000, 32'h7F7FFFFF, GT, "R10 +inf>max");
        send(32'hFF800000, 32'hFF7FFFFF, LT, "R10 -inf<-max");
        send(32'h7F800000, 32'h7F800000, EQ, "R10 inf=inf");
        send(32'hFF800000, 32'hFF800000, EQ, "R10 -inf=-inf");
        send(32'h7F800000, 32'hFF800000, GT, "R10 +inf>-inf");
        send(32'h00000002, 32'h00000001, GT, "R11 den order");
        send(32'h007FFFFF, 32'h00800000, LT, "R11 maxden<minnorm");
        send(32'h00000001, 32'h00000000, GT, "R11 den>0");
        send(32'h80000001, 32'h00000000, LT, "R11 -den<0");
        for (int i = 0; i < 400; i++) begin
          logic [31:0] a, b;
          a = {i[0], (i % 5 == 0) ? 8'hFF : ((i % 7 == 0) ? 8'h00 : 8'(i * 37)),
               (i % 3 == 0) ? 23'h0 : 23'(i * 7919)};
          b = {i[1], (i % 11 == 0) ? 8'hFF : ((i % 4 == 0) ? a[30:23] : 8'(i * 53)),
               (i % 6 == 0) ? a[22:0] : 23'(i * 104729)};
          send(a, b, model(a, b), "R1 R6 stream");
        end
        @(negedge clk);
        op_a = 32'h7FC00000;
        op_b = 32'h3F800000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 check({flag_eq, flag_gt, flag_lt, flag_inv}, 4'b0000, "R2 mid-run reset");
      end
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule